// File: doc/BRIEF.md
# Comparator Reference Hysteresis Controller

This block is the digital side of an analog comparator's reference path. A small register write port programs a control word and two threshold codes. From these settings, the live comparator output and the input-channel enables of the two comparator terminals, the block produces:

- the input code for an 8-bit reference DAC;
- the DAC enable and the DAC reference-input choice;
- a direct-reference bypass enable;
- routing enables for the positive and negative terminals;
- a fast or ultra-low-power request for the reference circuitry.

In hardware-controlled mode the DAC code flips between the two thresholds as the comparator output toggles, which gives hysteresis without external parts. In software mode a register bit picks the threshold. The DAC, the buffers and the comparator itself are analog and sit outside this block.

The write port is a plain strobe with no back-pressure. Every cycle with `wr_en` high commits one write. All other pins are level signals.

Top module: `cmp_ref_ctrl`

## Requirements
- R1: After reset every register field and both codes are 0. `dac_code`, `dac_en`, `dac_ref_ext`, `bypass_en`, `route_pos`, `route_neg`, `req_fast` and `req_ulp` are all 0.
- R2: The control word at address 0 holds the source select in bits [1:0]. `dac_en` is 1 exactly for source 1 (supply into DAC) and source 2 (external reference into DAC). `dac_ref_ext` is 1 only for source 2. `bypass_en` is 1 only for source 3 (external reference direct, DAC off).
- R3: While the source is 0 or 3, `dac_code` reads 0.
- R4: With control bit 3 at 0 (hardware mode) and the DAC enabled, `dac_code` equals code1 when the comparator output is 1 and code0 when it is 0. A change on `cmp_out` before a rising edge first shows on the third rising edge; after two edges the old code remains.
- R5: With control bit 3 at 1 (software mode), control bit 4 selects code1 (1) or code0 (0), and `cmp_out` has no effect on `dac_code`. The edge that captures the write updates the field, and the next edge updates the code.
- R6: Address 1 holds code0 and address 2 holds code1, each 8 bits wide. A new code appears on `dac_code` at the second rising edge after the write is presented.
- R7: With the source not 0, control bit 2 routes the reference to the positive terminal (0) or the negative terminal (1). At most one routing enable is ever high.
- R8: A channel enabled on the selected terminal takes precedence, and the routing enable for that terminal stays 0.
- R9: Control bit 5 requests fast operation (`req_fast`, bit 0) or ultra-low-power operation (`req_ulp`, bit 1). With source 0, both requests and both routing enables are 0.
- R10: A write to address 3 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| cmp_out | input | 1 | Asynchronous comparator output |
| chan_en_pos | input | 1 | Input channel enabled on positive terminal |
| chan_en_neg | input | 1 | Input channel enabled on negative terminal |
| dac_code | output | 8 | DAC input code |
| dac_en | output | 1 | DAC enable |
| dac_ref_ext | output | 1 | DAC reference input: 1 external, 0 supply |
| bypass_en | output | 1 | External reference connected directly |
| route_pos | output | 1 | Reference connected to positive terminal |
| route_neg | output | 1 | Reference connected to negative terminal |
| req_fast | output | 1 | Fast-mode reference request |
| req_ulp | output | 1 | Ultra-low-power reference request |

## Verification
The hardest case to reach from the ports is the exact timing of the synchronizer. A comparator edge must be shown to be invisible to the code for two cycles and visible on the third, while the thresholds differ and the block stays in hardware mode. Directed steps therefore hold `cmp_out` steady, flip it at one falling edge and sample after each following edge. Random rounds then mix sources, modes, terminal choices and channel enables, holding the comparator long enough to settle before each comparison. A write to the unused address carries data that would change the outputs if it aliased the control word.

// File: rtl/cref_pkg.sv
package cref_pkg;
  typedef enum logic [1:0] {
    SRC_OFF        = 2'd0,
    SRC_SUPPLY_DAC = 2'd1,
    SRC_EXT_DAC    = 2'd2,
    SRC_EXT_DIRECT = 2'd3
  } src_e;

  // packed MSB first: bit5 ulp, bit4 sw_sel, bit3 sw_mode, bit2 term_neg, [1:0] src
  typedef struct packed {
    logic ulp;
    logic sw_sel;
    logic sw_mode;
    logic term_neg;
    src_e src;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_CODE0 = 2'd1;
  localparam logic [1:0] ADDR_CODE1 = 2'd2;
endpackage

// File: rtl/cref_regs.sv
module cref_regs
  import cref_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  output ctrl_t             ctrl_o,
  output logic [CODE_W-1:0] code0_o,
  output logic [CODE_W-1:0] code1_o
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_CODE0 = ADDR_W'(ADDR_CODE0);
  localparam logic [ADDR_W-1:0] A_CODE1 = ADDR_W'(ADDR_CODE1);

  ctrl_t ctrl_q;
  logic [CODE_W-1:0] code0_q, code1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      code0_q <= '0;
      code1_q <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_CTRL:  ctrl_q  <= ctrl_t'(wr_data[CTRL_W-1:0]);
        A_CODE0: code0_q <= wr_data;
        A_CODE1: code1_q <= wr_data;
        default: ;
      endcase
    end
  end

  assign ctrl_o  = ctrl_q;
  assign code0_o = code0_q;
  assign code1_o = code1_q;
endmodule

// File: rtl/cref_sync.sv
module cref_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cref_code_sel.sv
module cref_code_sel #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_mode,
  input  logic              sw_sel,
  input  logic              cmp_sync,
  input  logic [CODE_W-1:0] code0,
  input  logic [CODE_W-1:0] code1,
  output logic [CODE_W-1:0] code_q
);
  logic pick_hi;
  logic [CODE_W-1:0] code_d;

  always_comb begin
    pick_hi = sw_mode ? sw_sel : cmp_sync;
    code_d  = pick_hi ? code1 : code0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end
endmodule

// File: rtl/cref_route.sv
module cref_route
  import cref_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  ctrl_t             ctrl,
  input  logic [CODE_W-1:0] code_q,
  input  logic              chan_en_pos,
  input  logic              chan_en_neg,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_en,
  output logic              dac_ref_ext,
  output logic              bypass_en,
  output logic              route_pos,
  output logic              route_neg,
  output logic              req_fast,
  output logic              req_ulp
);
  logic gen_on;

  always_comb begin
    gen_on      = (ctrl.src != SRC_OFF);
    dac_en      = (ctrl.src == SRC_SUPPLY_DAC) || (ctrl.src == SRC_EXT_DAC);
    dac_ref_ext = (ctrl.src == SRC_EXT_DAC);
    bypass_en   = (ctrl.src == SRC_EXT_DIRECT);
    dac_code    = dac_en ? code_q : '0;
    route_pos   = gen_on && !ctrl.term_neg && !chan_en_pos;
    route_neg   = gen_on &&  ctrl.term_neg && !chan_en_neg;
    req_fast    = gen_on && !ctrl.ulp;
    req_ulp     = gen_on &&  ctrl.ulp;
  end
endmodule

// File: rtl/cmp_ref_ctrl.sv
module cmp_ref_ctrl
  import cref_pkg::*;
#(
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              cmp_out,
  input  logic              chan_en_pos,
  input  logic              chan_en_neg,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_en,
  output logic              dac_ref_ext,
  output logic              bypass_en,
  output logic              route_pos,
  output logic              route_neg,
  output logic              req_fast,
  output logic              req_ulp
);
  ctrl_t ctrl;
  logic [CODE_W-1:0] code0, code1, code_q;
  logic cmp_sync;

  cref_regs #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_o(ctrl), .code0_o(code0), .code1_o(code1)
  );

  cref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_out), .q(cmp_sync)
  );

  cref_code_sel #(.CODE_W(CODE_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .sw_mode(ctrl.sw_mode), .sw_sel(ctrl.sw_sel),
    .cmp_sync(cmp_sync), .code0(code0), .code1(code1), .code_q(code_q)
  );

  cref_route #(.CODE_W(CODE_W)) u_route (
    .ctrl(ctrl), .code_q(code_q), .chan_en_pos(chan_en_pos),
    .chan_en_neg(chan_en_neg), .dac_code(dac_code), .dac_en(dac_en),
    .dac_ref_ext(dac_ref_ext), .bypass_en(bypass_en), .route_pos(route_pos),
    .route_neg(route_neg), .req_fast(req_fast), .req_ulp(req_ulp)
  );
endmodule

// File: rtl/cmp_ref_ctrl_chk.sv
module cmp_ref_ctrl_chk #(
  parameter int unsigned CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chan_en_pos,
  input logic              chan_en_neg,
  input logic [CODE_W-1:0] dac_code,
  input logic              dac_en,
  input logic              dac_ref_ext,
  input logic              bypass_en,
  input logic              route_pos,
  input logic              route_neg,
  input logic              req_fast,
  input logic              req_ulp
);
  p_dac_bypass_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(dac_en && bypass_en));

  p_ext_needs_dac_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dac_ref_ext |-> dac_en);

  p_code_zero_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_en |-> (dac_code == '0));

  p_route_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({route_pos, route_neg}));

  p_chan_pos_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en_pos |-> !route_pos);

  p_chan_neg_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en_neg |-> !route_neg);

  p_req_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_fast && req_ulp));

  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_en && !bypass_en) |-> (!req_fast && !req_ulp && !route_pos && !route_neg));
endmodule

bind cmp_ref_ctrl cmp_ref_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en_pos(chan_en_pos), .chan_en_neg(chan_en_neg),
  .dac_code(dac_code), .dac_en(dac_en), .dac_ref_ext(dac_ref_ext),
  .bypass_en(bypass_en), .route_pos(route_pos), .route_neg(route_neg),
  .req_fast(req_fast), .req_ulp(req_ulp)
);

// File: tb/cmp_ref_ctrl_tb.sv
module cmp_ref_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       cmp_out = 1'b0;
  logic       chan_en_pos = 1'b0;
  logic       chan_en_neg = 1'b0;
  logic [7:0] dac_code;
  logic dac_en, dac_ref_ext, bypass_en, route_pos, route_neg, req_fast, req_ulp;

  int n_chk = 0;
  int n_bad = 0;

  // bench model of the programmed state
  logic [5:0] m_ctrl = '0;
  logic [7:0] m_c0 = '0, m_c1 = '0;

  always #5 clk = ~clk;

  cmp_ref_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmp_out(cmp_out), .chan_en_pos(chan_en_pos), .chan_en_neg(chan_en_neg),
    .dac_code(dac_code), .dac_en(dac_en), .dac_ref_ext(dac_ref_ext),
    .bypass_en(bypass_en), .route_pos(route_pos), .route_neg(route_neg),
    .req_fast(req_fast), .req_ulp(req_ulp)
  );

  function automatic logic [7:0] exp_code(logic [5:0] c, logic cmp);
    logic sel;
    if (c[1:0] == 2'd0 || c[1:0] == 2'd3) return 8'h00;
    sel = c[3] ? c[4] : cmp;
    return sel ? m_c1 : m_c0;
  endfunction

  // {dac_en, dac_ref_ext, bypass_en, route_pos, route_neg, req_fast, req_ulp}
  function automatic logic [6:0] exp_flags(logic [5:0] c, logic cp, logic cn);
    logic on;
    on = (c[1:0] != 2'd0);
    return {(c[1:0] == 2'd1 || c[1:0] == 2'd2), (c[1:0] == 2'd2), (c[1:0] == 2'd3),
            on && !c[2] && !cp, on && c[2] && !cn, on && !c[5], on && c[5]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, {24'd0, dac_code}, {24'd0, exp_code(m_ctrl, cmp_out)});
    chk(req, {25'd0, dac_en, dac_ref_ext, bypass_en, route_pos, route_neg, req_fast, req_ulp},
        {25'd0, exp_flags(m_ctrl, chan_en_pos, chan_en_neg)});
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 2'd0) m_ctrl = d[5:0];
    else if (a == 2'd1) m_c0 = d;
    else if (a == 2'd2) m_c1 = d;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240607);
    step(3);
    // R1: reset state
    chk("R1", {24'd0, dac_code}, 32'd0);
    chk("R1", {25'd0, dac_en, dac_ref_ext, bypass_en, route_pos, route_neg, req_fast, req_ulp}, 32'd0);
    rst_n = 1'b1;
    step(2);
    chk_all("R1");

    // R6: codes then supply source, hardware mode
    wr(2'd1, 8'h3C);
    wr(2'd2, 8'hC5);
    wr(2'd0, 8'h01);
    step(1);
    chk_all("R6");
    chk("R6", {24'd0, dac_code}, 32'h3C);

    // R4: synchronizer latency on a comparator rise
    cmp_out = 1'b1;
    step(1); chk("R4", {24'd0, dac_code}, 32'h3C);
    step(1); chk("R4", {24'd0, dac_code}, 32'h3C);
    step(1); chk("R4", {24'd0, dac_code}, 32'hC5);
    cmp_out = 1'b0;
    step(2); chk("R4", {24'd0, dac_code}, 32'hC5);
    step(1); chk("R4", {24'd0, dac_code}, 32'h3C);

    // R6: new code0 visible at second edge after write
    wr(2'd1, 8'h5A);
    chk("R6", {24'd0, dac_code}, 32'h3C);
    step(1); chk("R6", {24'd0, dac_code}, 32'h5A);

    // R5: software mode, comparator ignored
    wr(2'd0, 8'h1A);  // src2, sw_mode, sw_sel=1
    chk("R2", {31'd0, dac_ref_ext}, 32'd1);
    step(1); chk("R5", {24'd0, dac_code}, 32'hC5);
    cmp_out = 1'b1; step(4); chk("R5", {24'd0, dac_code}, 32'hC5);
    cmp_out = 1'b0; step(4); chk("R5", {24'd0, dac_code}, 32'hC5);
    wr(2'd0, 8'h0A); step(1); chk("R5", {24'd0, dac_code}, 32'h5A);

    // R3/R2: direct external reference
    wr(2'd0, 8'h03);
    chk_all("R3");
    chk("R3", {24'd0, dac_code}, 32'd0);

    // R10: unused address does not alias the control word
    wr(2'd3, 8'h21);
    step(2);
    chk_all("R10");

    // R7/R8: terminal routing and channel precedence
    wr(2'd0, 8'h05);  // src1, negative terminal
    chan_en_neg = 1'b1; step(1); chk("R8", {31'd0, route_neg}, 32'd0);
    chan_en_neg = 1'b0; step(1); chk("R7", {30'd0, route_pos, route_neg}, 32'd1);
    chan_en_pos = 1'b1; step(1); chk("R7", {30'd0, route_pos, route_neg}, 32'd1);
    chan_en_pos = 1'b0;

    // R9: power request and source off
    wr(2'd0, 8'h21);
    chk("R9", {30'd0, req_fast, req_ulp}, 32'd1);
    wr(2'd0, 8'h20);
    chk_all("R9");

    // random rounds
    for (int i = 0; i < 300; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if (i % 5 == 0) wr(2'd1, 8'($urandom));
      if (i % 7 == 0) wr(2'd2, 8'($urandom));
      wr(2'($urandom_range(0, 3)), d);
      cmp_out = 1'($urandom);
      chan_en_pos = 1'($urandom);
      chan_en_neg = 1'($urandom);
      step(4);
      case (m_ctrl[1:0])
        2'd0: chk_all("R9");
        2'd3: chk_all("R3");
        default: chk_all(m_ctrl[3] ? "R5" : "R4");
      endcase
      chk_all(m_ctrl[2] ? "R8" : "R7");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule